// File: doc/BRIEF.md
# GPIO Controller with Routed Interrupt Lines

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins. Each pin owns two 32-bit control words. The first holds the output level, the buffer mode, the GPIO enable, the pull selection and a 4-bit route field. The second holds a 3-bit trigger code and an input-invert bit. Every pin input passes through a synchroniser and then an edge or level detector. A detected event is steered by the pin's route field onto one of 16 shared interrupt lines.

The 16 lines feed a status register, where a write of 1 clears a bit, and a mask register. The single interrupt output is the registered OR of status AND mask. Software reaches every register through a plain synchronous 32-bit bus. A read strobe returns data on the next cycle. There is no back-pressure: every access completes in one cycle, so no valid/ready handshake is used. Pin control words sit in chunks of 15 pins, and the chunks lie 0x400 apart. Offsets inside a chunk that do not map to a pin read as zero.

Top module: `gpio_route_ctrl`

## Requirements
- R1: After reset the status and mask registers read 0, the interrupt output is low, every control word reads 0 (apart from bit 0, which shows the synchronised input), and every output enable is low.
- R2: Pin p's first control word is at 0x4400 + (p/15)*0x400 + (p%15)*8, and its second word is 4 bytes above it. The first word keeps bits 31:28 (route), 23 (pull-up), 15 (GPIO enable), 10:8 (buffer mode) and 1 (output value). The second word keeps bits 6 (invert) and 2:0 (trigger). Every other bit reads 0, and a read of any unmapped offset returns 0 on the cycle after the read strobe.
- R3: pin_oe[p] is 1 exactly when GPIO enable is 1 and the buffer mode is 0 or 1. pin_out[p] equals bit 1 of the first control word.
- R4: Bit 0 of the first control word reads the pin input after a two-stage synchroniser, without inversion.
- R5: When the input path is on (GPIO enable 1 and buffer mode 0 or 2), trigger code 1 sets status bit [route] on a falling edge, code 2 on a rising edge and code 3 on either edge. An edge is a change between successive synchronised samples.
- R6: Trigger code 4 is level: status bit [route] is set in every cycle that the (optionally inverted) input is 1, so it returns at once after a clear while the pin stays active. Invert bit 6 makes a low pin active.
- R7: Status register at 0x300: writing 1 to a bit clears it, and writing 0 leaves it unchanged. A detect event in the same cycle as the clear leaves the bit set.
- R8: Mask register at 0x380 is read/write, with 1 enabling a line. The irq output equals the OR over the 16 lines of (status AND mask), one cycle after the status and mask values it reflects.
- R9: Events from pins that share a route value are ORed onto that line. Trigger code 0, or an input path that is off (buffer mode 1 or 3, or GPIO enable 0), produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | NUM_PINS | Pin input levels |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with NUM_PINS = 20. This fills one 15-pin chunk and part of a second, so it reaches the chunk stride, the unmapped holes left at the end of each chunk, and a pin count larger than the line count. Every pin is swept through all four trigger codes, with route values that rotate over all 16 lines. The buffer mode and enable combinations are swept exhaustively on one pin, and line sharing is tested with two pins on one line.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;
  localparam int LINES      = 16;
  localparam int LINE_W     = 4;
  localparam int CHUNK_PINS = 15;
  localparam logic [31:0] STAT_OFF     = 32'h0000_0300;
  localparam logic [31:0] MASK_OFF     = 32'h0000_0380;
  localparam logic [31:0] PIN_BASE     = 32'h0000_4400;
  localparam logic [31:0] CHUNK_STRIDE = 32'h0000_0400;
  localparam logic [31:0] SLOT_STRIDE  = 32'h0000_0008;

  typedef enum logic [2:0] {
    TRIG_NONE  = 3'd0,
    TRIG_FALL  = 3'd1,
    TRIG_RISE  = 3'd2,
    TRIG_BOTH  = 3'd3,
    TRIG_LEVEL = 3'd4
  } trig_e;

  function automatic logic [31:0] slot_addr(input int idx);
    return PIN_BASE + 32'(idx / CHUNK_PINS) * CHUNK_STRIDE
                    + 32'(idx % CHUNK_PINS) * SLOT_STRIDE;
  endfunction
endpackage

// File: rtl/gpio_pin_slot.sv
module gpio_pin_slot
  import gpio_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_c0,
  input  logic              wr_c1,
  input  logic [LINE_W-1:0] w_route,
  input  logic              w_pull,
  input  logic              w_en,
  input  logic [2:0]        w_mode,
  input  logic              w_tx,
  input  logic [2:0]        w_trig,
  input  logic              w_inv,
  input  logic              pin_in,
  output logic [31:0]       c0_rd,
  output logic [31:0]       c1_rd,
  output logic              oe,
  output logic              dout,
  output logic              evt,
  output logic [LINE_W-1:0] route
);
  logic              pull_q, en_q, tx_q, inv_q, prev_q;
  logic [2:0]        mode_q;
  logic [2:0]        trig_raw_q;
  logic [LINE_W-1:0] route_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic rx, lvl, in_on;
  trig_e trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0; pull_q <= 1'b0; en_q <= 1'b0; mode_q <= '0; tx_q <= 1'b0;
    end else if (wr_c0) begin
      route_q <= w_route; pull_q <= w_pull; en_q <= w_en; mode_q <= w_mode; tx_q <= w_tx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_raw_q <= '0; inv_q <= 1'b0;
    end else if (wr_c1) begin
      trig_raw_q <= w_trig; inv_q <= w_inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      prev_q <= lvl;
    end
  end

  assign rx    = sync_q[SYNC_STAGES-1];
  assign lvl   = rx ^ inv_q;
  assign in_on = en_q && (mode_q == 3'd0 || mode_q == 3'd2);
  assign trig  = trig_e'(trig_raw_q);

  always_comb begin
    evt = 1'b0;
    if (in_on) begin
      case (trig)
        TRIG_FALL:  evt = !lvl && prev_q;
        TRIG_RISE:  evt = lvl && !prev_q;
        TRIG_BOTH:  evt = lvl != prev_q;
        TRIG_LEVEL: evt = lvl;
        default:    evt = 1'b0;
      endcase
    end
  end

  assign oe    = en_q && (mode_q == 3'd0 || mode_q == 3'd1);
  assign dout  = tx_q;
  assign route = route_q;

  always_comb begin
    c0_rd        = '0;
    c0_rd[31:28] = route_q;
    c0_rd[23]    = pull_q;
    c0_rd[15]    = en_q;
    c0_rd[10:8]  = mode_q;
    c0_rd[1]     = tx_q;
    c0_rd[0]     = rx;
    c1_rd        = '0;
    c1_rd[6]     = inv_q;
    c1_rd[2:0]   = trig_raw_q;
  end
endmodule

// File: rtl/gpio_line_status.sv
module gpio_line_status
  import gpio_route_pkg::*;
#(
  parameter int NUM_PINS = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_evt,
  input  logic [NUM_PINS*LINE_W-1:0] pin_route,
  input  logic [LINES-1:0]           clr,
  input  logic                       mask_we,
  input  logic [LINES-1:0]           mask_wd,
  output logic [LINES-1:0]           line_evt,
  output logic [LINES-1:0]           stat_q,
  output logic [LINES-1:0]           mask_q,
  output logic                       irq
);
  always_comb begin
    line_evt = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (pin_evt[i]) line_evt[pin_route[i*LINE_W +: LINE_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | line_evt;
      if (mask_we) mask_q <= mask_wd;
      irq <= |(stat_q & mask_q);
    end
  end
endmodule

// File: rtl/gpio_route_ctrl.sv
module gpio_route_ctrl
  import gpio_route_pkg::*;
#(
  parameter int NUM_PINS    = 20,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int RW = NUM_PINS * LINE_W;

  logic [31:0]               addr_ext;
  logic [NUM_PINS-1:0]       hit0, hit1, pin_evt;
  logic [NUM_PINS-1:0][31:0] c0_rd, c1_rd;
  logic [RW-1:0]             pin_route;
  logic [LINES-1:0]          line_evt, stat_q, mask_q, clr;
  logic                      stat_hit, mask_hit;
  logic [31:0]               rd_mux;
  logic                      unused_hi;

  assign addr_ext  = 32'(bus_addr);
  assign stat_hit  = addr_ext == STAT_OFF;
  assign mask_hit  = addr_ext == MASK_OFF;
  assign clr       = (bus_wr && stat_hit) ? bus_wdata[LINES-1:0] : '0;
  assign unused_hi = ^{bus_wdata[27:24], bus_wdata[22:16]};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign hit0[p] = addr_ext == slot_addr(p);
    assign hit1[p] = addr_ext == slot_addr(p) + 32'd4;

    gpio_pin_slot #(.SYNC_STAGES(SYNC_STAGES)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_c0  (bus_wr && hit0[p]),
      .wr_c1  (bus_wr && hit1[p]),
      .w_route(bus_wdata[31:28]),
      .w_pull (bus_wdata[23]),
      .w_en   (bus_wdata[15]),
      .w_mode (bus_wdata[10:8]),
      .w_tx   (bus_wdata[1]),
      .w_trig (bus_wdata[2:0]),
      .w_inv  (bus_wdata[6]),
      .pin_in (pin_in[p]),
      .c0_rd  (c0_rd[p]),
      .c1_rd  (c1_rd[p]),
      .oe     (pin_oe[p]),
      .dout   (pin_out[p]),
      .evt    (pin_evt[p]),
      .route  (pin_route[p*LINE_W +: LINE_W])
    );
  end

  gpio_line_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_evt  (pin_evt),
    .pin_route(pin_route),
    .clr      (clr),
    .mask_we  (bus_wr && mask_hit),
    .mask_wd  (bus_wdata[LINES-1:0]),
    .line_evt (line_evt),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (stat_hit) rd_mux = 32'(stat_q);
    if (mask_hit) rd_mux = 32'(mask_q);
    for (int i = 0; i < NUM_PINS; i++) begin
      if (hit0[i]) rd_mux = rd_mux | c0_rd[i];
      if (hit1[i]) rd_mux = rd_mux | c1_rd[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_mux : '0;
  end
endmodule

// File: rtl/gpio_route_ctrl_chk.sv
module gpio_route_ctrl_chk
  import gpio_route_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [LINES-1:0]  ev,
  input logic [LINES-1:0]  st,
  input logic [LINES-1:0]  mk,
  input logic              irq
);
  logic stat_wr;
  assign stat_wr = bus_wr && (bus_addr == STAT_OFF[ADDR_W-1:0]);

  // R1: reset clears status and mask
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (st == '0 && mk == '0));

  // R8: irq follows masked status one cycle later
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(st & mk)));

  // R7: written ones clear bits that see no event
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (st & $past(bus_wdata[LINES-1:0] & ~ev)) == '0);

  // R5: a line event sets its status bit
  p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> (st & $past(ev)) == $past(ev));

  // R7: without write or event status holds
  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && ev == '0) |=> st == $past(st));
endmodule

bind gpio_route_ctrl gpio_route_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .ev       (line_evt),
  .st       (stat_q),
  .mk       (mask_q),
  .irq      (irq)
);

// File: tb/gpio_route_ctrl_tb.sv
module gpio_route_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 20;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_route_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  function automatic logic [15:0] a0(input int p);
    return 16'(32'h4400 + (p / 15) * 32'h400 + (p % 15) * 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp;
    logic [NP-1:0] pat;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(16'h0300, d); check("R1 status", d, 0);
    rd(16'h0380, d); check("R1 mask", d, 0);
    rd(a0(0), d); check("R1 ctl0", d, 0);
    rd(a0(19) + 16'd4, d); check("R1 ctl1", d, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 oe", 32'(pin_oe), 0);

    // R2 address map and field storage, enable kept 0
    for (int p = 0; p < NP; p++) begin
      wr(a0(p), 32'(p % 16) << 28 | 32'(p & 1) << 23 | 32'(p % 4) << 8
                | 32'((p >> 1) & 1) << 1 | 32'h0F7F_707D);
      wr(a0(p) + 16'd4, ((p & 1) ? 32'hFFFF_FFF8 : 32'hFFFF_FFB8) | 32'(p % 5));
    end
    for (int p = 0; p < NP; p++) begin
      exp = 32'(p % 16) << 28 | 32'(p & 1) << 23 | 32'(p % 4) << 8 | 32'((p >> 1) & 1) << 1;
      rd(a0(p), d); check("R2 ctl0 readback", d, exp);
      rd(a0(p) + 16'd4, d); check("R2 ctl1 readback", d, ((p & 1) ? 32'h40 : 32'h0) | 32'(p % 5));
    end
    rd(16'h4478, d); check("R2 hole chunk0", d, 0);
    rd(16'h4828, d); check("R2 hole chunk1", d, 0);
    rd(16'h4402, d); check("R2 misaligned", d, 0);
    rd(16'h0000, d); check("R2 offset zero", d, 0);
    for (int p = 0; p < NP; p++) begin
      wr(a0(p), 0); wr(a0(p) + 16'd4, 0);
    end

    // R3 output enable and data, exhaustive over enable and mode
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 8; m++) begin
        wr(a0(3), 32'(e) << 15 | 32'(m) << 8 | 32'(m & 1) << 1);
        idle(1);
        check("R3 oe", 32'(pin_oe), (e == 1 && m <= 1) ? 32'h8 : 32'h0);
        check("R3 out", 32'(pin_out), (m & 1) ? 32'h8 : 32'h0);
      end
    end
    wr(a0(3), 0);

    // R4 synchronised input readback
    for (int k = 0; k < 2; k++) begin
      pat = (k == 0) ? 20'h5A3C9 : ~20'h5A3C9;
      pin_in = pat;
      idle(4);
      for (int p = 0; p < NP; p++) begin
        rd(a0(p), d); check("R4 rx bit", d, 32'(pat[p]));
      end
    end
    pin_in = '0;
    idle(4);

    // R5 R6 R7 sweep over every pin and trigger code
    for (int p = 0; p < NP; p++) begin
      for (int t = 1; t <= 4; t++) begin
        int ln;
        ln = (p + t) % 16;
        wr(a0(p), 32'(ln) << 28 | 32'h8000 | 32'h200);
        wr(a0(p) + 16'd4, 32'(t));
        wr(16'h0300, 32'hFFFF);
        rd(16'h0300, d); check("R5 quiet", d, 0);
        pin_in[p] = 1'b1; idle(5);
        rd(16'h0300, d); check("R5 rise", d, (t >= 2) ? (32'h1 << ln) : 0);
        wr(16'h0300, 32'h1 << ln);
        rd(16'h0300, d); check("R6 R7 after clear", d, (t == 4) ? (32'h1 << ln) : 0);
        pin_in[p] = 1'b0; idle(5);
        rd(16'h0300, d);
        check("R5 fall", d, (t == 1 || t == 3 || t == 4) ? (32'h1 << ln) : 0);
        wr(16'h0300, 32'hFFFF);
        rd(16'h0300, d); check("R7 cleared", d, 0);
        wr(a0(p) + 16'd4, 0); wr(a0(p), 0);
      end
    end

    // R9 disabled path and trigger 0
    wr(a0(5), 32'h8000 | 32'h300 | 32'h2 << 28);
    wr(a0(5) + 16'd4, 32'h2);
    pin_in[5] = 1'b1; idle(5);
    rd(16'h0300, d); check("R9 mode3 no event", d, 0);
    pin_in[5] = 1'b0; idle(4);
    wr(a0(5), 32'h8000 | 32'h200 | 32'h2 << 28);
    wr(a0(5) + 16'd4, 32'h0);
    pin_in[5] = 1'b1; idle(5);
    rd(16'h0300, d); check("R9 trig0 no event", d, 0);
    pin_in[5] = 1'b0; idle(4);
    wr(a0(5), 0);

    // R6 inverted level
    wr(a0(7), 32'h3 << 28 | 32'h8000 | 32'h200);
    wr(a0(7) + 16'd4, 32'h44);
    idle(3);
    rd(16'h0300, d); check("R6 inverted low active", d, 32'h8);
    pin_in[7] = 1'b1; idle(4);
    wr(16'h0300, 32'hFFFF);
    rd(16'h0300, d); check("R6 inverted high idle", d, 0);
    wr(a0(7) + 16'd4, 0); wr(a0(7), 0);
    pin_in[7] = 1'b0; idle(4);
    wr(16'h0300, 32'hFFFF);

    // R9 shared line
    wr(a0(2), 32'h6 << 28 | 32'h8200); wr(a0(2) + 16'd4, 32'h2);
    wr(a0(9), 32'h6 << 28 | 32'h8000); wr(a0(9) + 16'd4, 32'h2);
    pin_in[9] = 1'b1; idle(5);
    rd(16'h0300, d); check("R9 shared second pin", d, 32'h40);
    wr(16'h0300, 32'hFFFF);
    pin_in[2] = 1'b1; idle(5);
    rd(16'h0300, d); check("R9 shared first pin", d, 32'h40);
    for (int p = 0; p < NP; p++) begin
      wr(a0(p), 0); wr(a0(p) + 16'd4, 0);
    end
    pin_in = '0; idle(4);
    wr(16'h0300, 32'hFFFF);

    // R8 mask and irq
    wr(a0(4), 32'hB << 28 | 32'h8200); wr(a0(4) + 16'd4, 32'h4);
    pin_in[4] = 1'b1; idle(5);
    check("R8 masked irq low", 32'(irq), 0);
    wr(16'h0380, 32'h0800); idle(3);
    check("R8 irq high", 32'(irq), 1);
    rd(16'h0380, d); check("R8 mask readback", d, 32'h0800);
    wr(16'h0380, 32'hF7FF); idle(3);
    check("R8 other lines irq low", 32'(irq), 0);
    wr(16'h0380, 32'hFFFF);
    pin_in[4] = 1'b0; idle(4);
    wr(16'h0300, 32'hFFFF); idle(3);
    check("R8 irq after clear", 32'(irq), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule